// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates interrupt and reset requests for a small 8-bit CPU core and supplies the 16-bit address of the vector the core must fetch. Ten maskable hardware sources are grouped onto six vectors. Each source has its own pending flag and enable bit, and the CPU's I bit inhibits the whole class. Three reset requests share one unmaskable vector. A software interrupt is entered as a pending request when the core fetches its opcode. From that point it outranks every hardware source except reset.

The request to the core behaves as a valid/ready pair. `irq_req` is the valid and `irq_ack` is the core's single-cycle ready. The core may hold `irq_ack` low for as long as it wants: the request stays up and the winner tracks the live flags until the acknowledge. When the acknowledge arrives, the current winner's vector is latched. From then on the request stays low until the core reports that the first handler instruction has completed. The vector base moves down by 16 bytes in self-check mode.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Any active reset request drives `core_rst`, `set_ibit` and the reset vector (offset 0xE) in the same cycle, with no clock needed. The reset requests are `por_req`, `pin_rst_req`, or `wdog_rst_req` while `wdog_rst_en`=1. After the last request drops, `core_rst` stays high across one clock edge and falls at the second edge. While `core_rst` is high, acknowledges and SWI fetches are ignored.
- R2: `wdog_rst_req` has no effect while `wdog_rst_en`=0.
- R3: Hardware source bit i is eligible only when `src_pend[i]`=1, `src_en[i]`=1 and `ibit`=0.
- R4: Among eligible sources, the lowest bit index wins. The bit map and vector offsets are as follows:
  - bits 0 and 1 (IRQ1, IRQ2) map to offset 0xA;
  - bit 2 (keyboard wakeup) maps to 0x8;
  - bits 3, 4 and 5 (timer 1 capture, compare, overflow) map to 0x6;
  - bits 6 and 7 (timer 2) map to 0x4;
  - bit 8 (serial port) maps to 0x2;
  - bit 9 (timebase) maps to 0x0.
- R5: `vec_addr` is 0xFFF0 plus the offset when `self_check`=0, and 0xFFE0 plus the offset when `self_check`=1. The base follows `self_check` at all times.
- R6: `irq_req` is high when a winner exists, no sequence is in progress and reset is inactive. An `irq_ack` while `irq_req`=1 latches the winner, and `vec_addr` shows it from the next cycle. Flag changes after the acknowledge do not alter it. `vec_addr` shows the reset vector from reset until the first acknowledge.
- R7: `set_ibit` is high for exactly the one cycle that follows an accepted acknowledge, and also whenever `core_rst` is high.
- R8: After an accepted acknowledge, `irq_req` stays low until an `insn_done` pulse. It may rise again in the cycle after that pulse.
- R9: A `swi_fetch` pulse raises `irq_req` in the next cycle even when `ibit`=1. The SWI vector (offset 0xC) then wins over every hardware source until it is acknowledged.
- R10: A `swi_fetch` during a sequence in progress does not raise `irq_req` before `insn_done`. It is served afterwards.
- R11: An `irq_ack` while `irq_req`=0 changes neither `vec_addr` nor `set_ibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request |
| pin_rst_req | input | 1 | External reset pin request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| wdog_rst_en | input | 1 | Watchdog reset enable |
| src_pend | input | 10 | Hardware pending flags (bit map in R4) |
| src_en | input | 10 | Per-source enables |
| ibit | input | 1 | CPU class inhibit bit |
| swi_fetch | input | 1 | SWI opcode fetched (one-cycle pulse) |
| insn_done | input | 1 | First handler instruction completed (pulse) |
| self_check | input | 1 | Self-check mode, lowers vector base |
| irq_ack | input | 1 | Core acknowledge (ready) |
| irq_req | output | 1 | Request to core (valid) |
| vec_addr | output | 16 | Vector address |
| set_ibit | output | 1 | Core must set its I bit |
| core_rst | output | 1 | Reset in force |

## Verification
The reset outputs and the self-check base are combinational, so they are due in the same cycle as the input change. `irq_req` responds in the same cycle to flag, enable and I-bit changes. It responds one cycle after `swi_fetch`, after the acknowledge and after `insn_done`. `vec_addr` and `set_ibit` reflect an acknowledge one edge later. `core_rst` falls at the second edge after the last reset request drops. Inputs are driven just after a rising edge. A behavioural reference model advances at the same edge, and every output is compared with it at the falling edge. Directed checks at the falling edge also test each of these latencies against literal values.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC = 10;
  localparam int IDXW = 3;

  typedef enum logic [IDXW-1:0] {
    V_TB   = 3'd0,
    V_SPI  = 3'd1,
    V_TMR2 = 3'd2,
    V_TMR1 = 3'd3,
    V_KWI  = 3'd4,
    V_IRQ  = 3'd5,
    V_SWI  = 3'd6,
    V_RST  = 3'd7
  } vec_e;

  // source bit -> shared vector group; bit order is priority order
  function automatic vec_e src_group(input int idx);
    case (idx)
      0, 1:    return V_IRQ;
      2:       return V_KWI;
      3, 4, 5: return V_TMR1;
      6, 7:    return V_TMR2;
      8:       return V_SPI;
      default: return V_TB;
    endcase
  endfunction
endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_req,
  output logic rst_hold
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge rst_req) begin
    if (rst_req) sh <= '1;
    else         sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_hold = sh[STAGES-1];
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] elig,
  output logic         any,
  output vec_e         grp
);
  always_comb begin
    any = 1'b0;
    grp = V_TB;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        grp = src_group(i);
      end
    end
  end
endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
  import ivc_pkg::*;
(
  input  logic clk,
  input  logic rst_any,
  input  logic rst_hold,
  input  logic hw_any,
  input  vec_e hw_grp,
  input  logic swi_fetch,
  input  logic ack,
  input  logic insn_done,
  output logic req,
  output vec_e vec_q,
  output logic take_q,
  output logic busy,
  output logic swi_pend
);
  logic take;

  assign req  = !rst_any && !rst_hold && !busy && (swi_pend || hw_any);
  assign take = req && ack;

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) begin
      vec_q    <= V_RST;
      take_q   <= 1'b0;
      busy     <= 1'b0;
      swi_pend <= 1'b0;
    end else if (rst_hold) begin
      vec_q    <= V_RST;
      take_q   <= 1'b0;
      busy     <= 1'b0;
      swi_pend <= 1'b0;
    end else begin
      take_q <= take;
      if (take) vec_q <= swi_pend ? V_SWI : hw_grp;
      if (take)           busy <= 1'b1;
      else if (insn_done) busy <= 1'b0;
      if (swi_fetch)             swi_pend <= 1'b1;
      else if (take && swi_pend) swi_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SYNC_STG   = 2,
  parameter logic [11:0] USER_BASE  = 12'hFFF,
  parameter logic [11:0] CHECK_BASE = 12'hFFE
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              pin_rst_req,
  input  logic              wdog_rst_req,
  input  logic              wdog_rst_en,
  input  logic [NSRC-1:0]   src_pend,
  input  logic [NSRC-1:0]   src_en,
  input  logic              ibit,
  input  logic              swi_fetch,
  input  logic              insn_done,
  input  logic              self_check,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_ibit,
  output logic              core_rst
);
  localparam int BASE_W = ADDR_W - IDXW - 1;

  logic            rst_any, rst_hold, rst_out;
  logic [NSRC-1:0] elig;
  logic            hw_any, take_q, busy, swi_pend;
  vec_e            hw_grp, vec_q, vec_sel;
  logic [BASE_W-1:0] base;

  assign rst_any = por_req | pin_rst_req | (wdog_rst_req & wdog_rst_en);
  assign rst_out = rst_any | rst_hold;

  ivc_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_req(rst_any), .rst_hold(rst_hold)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    assign elig[g] = src_pend[g] & src_en[g] & ~ibit;
  end

  ivc_arbiter #(.N(NSRC)) u_arb (.elig(elig), .any(hw_any), .grp(hw_grp));

  ivc_seq u_seq (
    .clk(clk), .rst_any(rst_any), .rst_hold(rst_hold),
    .hw_any(hw_any), .hw_grp(hw_grp), .swi_fetch(swi_fetch),
    .ack(irq_ack), .insn_done(insn_done), .req(irq_req),
    .vec_q(vec_q), .take_q(take_q), .busy(busy), .swi_pend(swi_pend)
  );

  assign base     = self_check ? CHECK_BASE[BASE_W-1:0] : USER_BASE[BASE_W-1:0];
  assign vec_sel  = rst_out ? V_RST : vec_q;
  assign vec_addr = {base, vec_sel, 1'b0};
  assign set_ibit = rst_out | take_q;
  assign core_rst = rst_out;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NS = 10,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_any,
  input logic          rst_out,
  input logic          busy,
  input logic          swi_pend,
  input logic [NS-1:0] src_pend,
  input logic [NS-1:0] src_en,
  input logic          ibit,
  input logic          self_check,
  input logic          irq_ack,
  input logic          irq_req,
  input logic [AW-1:0] vec_addr,
  input logic          set_ibit,
  input logic          core_rst
);
  always_ff @(posedge clk) begin
    if (rst_any)
      p_rst_vec_r1: assert (core_rst && set_ibit && vec_addr[3:0] == 4'hE);
  end

  p_class_mask_r3: assert property (@(posedge clk) disable iff (rst_out)
    (irq_req && !swi_pend) |-> (!ibit && |(src_pend & src_en)));

  p_ack_accept_r7: assert property (@(posedge clk) disable iff (rst_out)
    (irq_req && irq_ack) |=> (set_ibit && !irq_req));

  p_ibit_cause_r7: assert property (@(posedge clk) disable iff (rst_out)
    set_ibit |-> $past(irq_req && irq_ack));

  p_vec_hold_r6: assert property (@(posedge clk) disable iff (rst_out)
    (!(irq_req && irq_ack) && !self_check) |=> (!self_check -> $stable(vec_addr)));

  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst_out)
    busy |-> !irq_req);

  p_swi_unmasked_r9: assert property (@(posedge clk) disable iff (rst_out)
    (swi_pend && !busy) |-> irq_req);

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (rst_out)
    (irq_ack && !irq_req) |=> !set_ibit);
endmodule

bind irq_vec_ctrl ivc_checker #(.NS(ivc_pkg::NSRC), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_any(rst_any), .rst_out(rst_out), .busy(busy),
  .swi_pend(swi_pend), .src_pend(src_pend), .src_en(src_en), .ibit(ibit),
  .self_check(self_check), .irq_ack(irq_ack), .irq_req(irq_req),
  .vec_addr(vec_addr), .set_ibit(set_ibit), .core_rst(core_rst)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       por_req = 1'b1, pin_rst_req = 1'b0, wdog_rst_req = 1'b0, wdog_rst_en = 1'b0;
  logic [9:0] src_pend = '0, src_en = '0;
  logic       ibit = 1'b1, swi_fetch = 1'b0, insn_done = 1'b0, self_check = 1'b0, irq_ack = 1'b0;
  logic        irq_req, set_ibit, core_rst;
  logic [15:0] vec_addr;

  irq_vec_ctrl u0 (
    .clk(clk), .por_req(por_req), .pin_rst_req(pin_rst_req),
    .wdog_rst_req(wdog_rst_req), .wdog_rst_en(wdog_rst_en),
    .src_pend(src_pend), .src_en(src_en), .ibit(ibit), .swi_fetch(swi_fetch),
    .insn_done(insn_done), .self_check(self_check), .irq_ack(irq_ack),
    .irq_req(irq_req), .vec_addr(vec_addr), .set_ibit(set_ibit), .core_rst(core_rst)
  );

  int    n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;

  // ---------------- reference model ----------------
  int m_sync = 2;
  bit m_busy = 0, m_swi = 0, m_take = 0;
  int m_vec = 14;

  function automatic int grp_off(int b);
    if (b <= 1) return 10;
    if (b == 2) return 8;
    if (b <= 5) return 6;
    if (b <= 7) return 4;
    if (b == 8) return 2;
    return 0;
  endfunction

  function automatic bit m_rany();
    return por_req || pin_rst_req || (wdog_rst_req && wdog_rst_en);
  endfunction

  function automatic int m_hw(); // offset of winner, -1 if none
    if (ibit) return -1;
    for (int b = 0; b < 10; b++) if (src_pend[b] && src_en[b]) return grp_off(b);
    return -1;
  endfunction

  function automatic bit m_rout();
    return m_rany() || (m_sync > 0);
  endfunction

  function automatic bit m_req();
    return !m_rout() && !m_busy && (m_swi || m_hw() >= 0);
  endfunction

  always @(posedge clk) begin
    bit r, tk;
    int w;
    r  = m_rout();
    tk = m_req() && irq_ack;
    w  = m_swi ? 12 : m_hw();
    if (r) begin
      m_busy = 0; m_swi = 0; m_take = 0; m_vec = 14;
    end else begin
      if (tk) m_vec = w;
      if (swi_fetch) m_swi = 1; else if (tk && m_swi) m_swi = 0;
      if (tk) m_busy = 1; else if (insn_done) m_busy = 0;
      m_take = tk;
    end
    m_sync = m_rany() ? 2 : (m_sync > 0 ? m_sync - 1 : 0);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [15:0] ev;
    ev = {self_check ? 12'hFFE : 12'hFFF, 4'(m_rout() ? 14 : m_vec)};
    check({phase, " core_rst"}, 32'(core_rst), 32'(m_rout()));
    check({phase, " irq_req"},  32'(irq_req),  32'(m_req()));
    check({phase, " set_ibit"}, 32'(set_ibit), 32'(m_rout() || m_take));
    check({phase, " vec_addr"}, 32'(vec_addr), 32'(ev));
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic mid();
    @(negedge clk); #0.1;
  endtask
  task automatic pulse_ack();
    irq_ack = 1; cyc(); irq_ack = 0;
  endtask
  task automatic pulse_done();
    insn_done = 1; cyc(); insn_done = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    cmp_on = 1;
    // R1 reset hold and release timing
    phase = "R1";
    mid(); check("R1 vec during por", 32'(vec_addr), 32'hFFFE);
    check("R1 set_ibit during por", 32'(set_ibit), 1);
    por_req = 0; cyc();
    mid(); check("R1 hold after 1 edge", 32'(core_rst), 1);
    cyc();
    mid(); check("R1 released after 2 edges", 32'(core_rst), 0);
    pin_rst_req = 1; #0.5; check("R1 pin reset async", 32'(core_rst), 1);
    cyc(); pin_rst_req = 0; cyc(3);
    // R2 watchdog gating
    phase = "R2";
    wdog_rst_req = 1; cyc(); mid();
    check("R2 wdog ignored when disabled", 32'(core_rst), 0);
    wdog_rst_en = 1; #0.5; check("R2 wdog enabled resets", 32'(core_rst), 1);
    cyc(); wdog_rst_req = 0; wdog_rst_en = 0; cyc(3);
    // R3 masking
    phase = "R3";
    src_pend = 10'b1; src_en = 10'b1; ibit = 1; cyc(); mid();
    check("R3 ibit masks", 32'(irq_req), 0);
    ibit = 0; src_en = 0; cyc(); mid();
    check("R3 local enable masks", 32'(irq_req), 0);
    src_en = '1; cyc(); mid();
    check("R3 eligible requests", 32'(irq_req), 1);
    // R6 R7 R8 handshake
    phase = "R6";
    src_pend = '1; pulse_ack(); src_pend = 10'b0000000100; mid();
    check("R6 latched IRQ vector", 32'(vec_addr), 32'hFFFA);
    check("R7 set_ibit pulse", 32'(set_ibit), 1);
    check("R8 quiet after ack", 32'(irq_req), 0);
    cyc(); mid();
    check("R7 pulse ends", 32'(set_ibit), 0);
    check("R6 vec unaffected by flags", 32'(vec_addr), 32'hFFFA);
    phase = "R8";
    cyc(3); mid(); check("R8 still quiet", 32'(irq_req), 0);
    pulse_done(); mid(); check("R8 req after done", 32'(irq_req), 1);
    // R4 R5 priority walk, both bases
    for (int b = 0; b < 10; b++) begin
      phase = "R4";
      self_check = b[0];
      src_pend = 10'h3FF << b; cyc();
      pulse_ack(); mid();
      check("R4 R5 winner vector", 32'(vec_addr),
            32'({b[0] ? 12'hFFE : 12'hFFF, 4'(grp_off(b))}));
      pulse_done();
    end
    phase = "R5";
    self_check = 0; #0.5; check("R5 base follows mode", 32'(vec_addr[15:4]), 32'hFFF);
    // R9 SWI
    phase = "R9";
    src_pend = '1; ibit = 1; cyc(); swi_fetch = 1; cyc(); swi_fetch = 0; mid();
    check("R9 swi req despite ibit", 32'(irq_req), 1);
    ibit = 0; cyc(2); pulse_ack(); mid();
    check("R9 swi vector over hw", 32'(vec_addr), 32'hFFFC);
    // R10 SWI during sequence
    phase = "R10";
    swi_fetch = 1; cyc(); swi_fetch = 0; src_pend = '0; cyc(2); mid();
    check("R10 no preempt", 32'(irq_req), 0);
    pulse_done(); mid(); check("R10 served after", 32'(irq_req), 1);
    pulse_ack(); mid(); check("R10 swi vector", 32'(vec_addr), 32'hFFFC);
    pulse_done();
    // R11 stray ack
    phase = "R11";
    cyc(); irq_ack = 1; cyc(); irq_ack = 0; mid();
    check("R11 no set_ibit", 32'(set_ibit), 0);
    check("R11 vector kept", 32'(vec_addr), 32'hFFFC);
    // random stress against model
    phase = "R6 random";
    for (int k = 0; k < 3000; k++) begin
      src_pend   = 10'($urandom);
      src_en     = 10'($urandom);
      ibit       = ($urandom % 4) == 0;
      swi_fetch  = ($urandom % 16) == 0;
      irq_ack    = ($urandom % 3) == 0;
      insn_done  = ($urandom % 5) == 0;
      self_check = ($urandom % 8) == 0;
      pin_rst_req  = ($urandom % 200) == 0;
      wdog_rst_req = ($urandom % 100) == 0;
      wdog_rst_en  = $urandom % 2;
      cyc();
    end
    {pin_rst_req, wdog_rst_req, swi_fetch, irq_ack, insn_done} = '0;
    cyc(3);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule